// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level translation structure held in external memory. A walk starts from a one-cycle start pulse. The block samples the linear address, the access kind (read or write), the requester privilege (user or supervisor), the paging enable and the directory base. It then fetches one directory entry and one table entry over a single-outstanding request/acknowledge memory port. Memory is addressed in 32-bit words, and pages are 4 KB. The linear address splits into three fields: a 10-bit directory index in bits 31..22, a 10-bit table index in bits 21..12 and a 12-bit page offset in bits 11..0.

Entries use the following layout:
- bit 0 is "present"
- bit 1 is "writable"
- bit 2 is "user allowed"
- bit 5 is "accessed"
- bit 6 is "dirty" (table entries only)
- bits 31..12 give the next-level frame

When an entry is missing the walk stops. It also stops when the access breaks the combined protection of both levels. In either case it raises a fault and keeps the faulting linear address in a fault-address register, which plays the role of CR2. Otherwise the block writes back any accessed or dirty bit that must change, then reports the translated address. With paging off the address passes straight through and memory is not touched.

Top module: `pageWalker`

## Requirements
- R1: After reset the block is idle: `memReq`, `walkDone` and `walkFault` are low and `faultAddr` and `faultErr` are zero.
- R2: When `pagingOn` is low at start, the walk finishes in one cycle with `walkDone` high and `physAddr` equal to the linear address, and it issues no memory request.
- R3: The directory entry is read at {`cr3Base`[31:12], dir index, 2'b00}. The table entry is read at {directory entry[31:12], table index, 2'b00}. Only one request is outstanding, and `memReq`, `memWe` and `memAddr` hold steady until `memAck`.
- R4: A successful walk raises `walkDone` for exactly one cycle with `physAddr` = {table entry[31:12], offset}. `walkDone` and `walkFault` are never high together.
- R5: An entry with bit 0 clear, at either level, ends the walk with `walkFault` and `faultErr`[0] = 0.
- R6: Protection uses the AND of the directory and table bits. A user access faults when the combined bit 2 is 0. A user write faults when the combined bit 1 is 0. A supervisor access never takes a protection fault. A protection fault sets `faultErr`[0] = 1.
- R7: If the directory entry has bit 5 clear, the entry is written back with bit 5 set before the table entry is read. Otherwise it is not written.
- R8: A table entry is written back only when bit 5 is clear, or when the access is a write and bit 6 is clear. The written value sets bit 5, and also bit 6 for writes. A table entry that faults is never written.
- R9: On a fault `faultAddr` takes the linear address of the walk. At all other times it keeps its value.
- R10: On a fault `faultErr`[1] is the write flag and `faultErr`[2] is the user flag of the walk.
- R11: A start pulse, or a change of the address inputs, while a walk is in progress has no effect on that walk and does not start another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse, sampled when idle |
| linAddr | input | 32 | Linear address to translate |
| isWrite | input | 1 | 1 = write access |
| isUser | input | 1 | 1 = user privilege, 0 = supervisor |
| pagingOn | input | 1 | Translation enable |
| cr3Base | input | 32 | Directory physical base (low 12 bits ignored) |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry value for write-back |
| memAck | input | 1 | One-cycle completion of the current request |
| memRdata | input | 32 | Read data, valid with `memAck` |
| walkDone | output | 1 | One-cycle success pulse |
| walkFault | output | 1 | One-cycle fault pulse |
| physAddr | output | 32 | Translated address, valid with `walkDone` |
| faultAddr | output | 32 | Last faulting linear address |
| faultErr | output | 3 | Cause of last fault: {user, write, protection} |

## Verification
Errors in the captured entries show up at the ports within one memory round trip. A wrong frame latched from the directory sends the table read to the wrong word, and the resulting `physAddr` or fault decision differs at the next `walkDone` or `walkFault`. A wrong state decision shows up as extra or missing write-backs, which the bench counts per walk, or as stale entry contents read back after the walk. A fault-address register that reloads without cause shows up as a change in `faultAddr` on a later successful walk.

// File: rtl/walker_pkg.sv
package walker_pkg;

  // Entry flag positions; the external tables are decoded with this layout.
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WR_DIR,
    ST_RD_TBL,
    ST_WR_TBL,
    ST_FIN,
    ST_FLT
  } walkState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;    // sample request inputs
    logic latchDir;   // store directory entry from read data
    logic latchTbl;   // store table entry from read data
    logic selTbl;     // address/write data refer to table level
    logic doWrite;    // a write-back is on the port
    logic loadCr2;    // record fault address and cause
    logic faultProt;  // recorded cause is a protection failure
  } walkStrobe_t;

endpackage

// File: rtl/walkPath.sv
module walkPath
  import walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       stb,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              isUser,
  input  logic              pagingOn,
  input  logic [ADDR_W-1:0] cr3Base,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [2:0]        faultErr,
  output logic              rdPresent,
  output logic              dirNeedsWb,
  output logic              tblNeedsWb,
  output logic              protOk
);

  localparam int FRAME_W   = ADDR_W - OFF_W;
  localparam int DIR_W     = ADDR_W - OFF_W - IDX_W;
  localparam int ENT_SHIFT = OFF_W - IDX_W;   // log2 of entry size in bytes
  localparam int TBL_LO    = OFF_W;
  localparam int TBL_HI    = OFF_W + IDX_W - 1;
  localparam int DIR_LO    = OFF_W + IDX_W;
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(1) << BIT_A;
  localparam logic [ADDR_W-1:0] MASK_D = ADDR_W'(1) << BIT_D;

  logic [ADDR_W-1:0]  linReg;
  logic               wrReg;
  logic               usrReg;
  logic               pgReg;
  logic [FRAME_W-1:0] cr3Frame;
  logic [ADDR_W-1:0]  dirEnt;
  logic [ADDR_W-1:0]  tblEnt;
  logic [ADDR_W-1:0]  cr2Reg;
  logic [2:0]         errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linReg   <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      pgReg    <= 1'b0;
      cr3Frame <= '0;
      dirEnt   <= '0;
      tblEnt   <= '0;
      cr2Reg   <= '0;
      errReg   <= '0;
    end else begin
      if (stb.capture) begin
        linReg   <= linAddr;
        wrReg    <= isWrite;
        usrReg   <= isUser;
        pgReg    <= pagingOn;
        cr3Frame <= cr3Base[ADDR_W-1:OFF_W];
      end
      if (stb.latchDir) dirEnt <= memRdata;
      if (stb.latchTbl) tblEnt <= memRdata;
      if (stb.loadCr2) begin
        cr2Reg <= linReg;
        errReg <= {usrReg, wrReg, stb.faultProt};
      end
    end
  end

  // Entry addresses: frame base plus index scaled by the entry size.
  logic [ADDR_W-1:0] dirAddr;
  logic [ADDR_W-1:0] tblAddr;
  logic [DIR_W-1:0]  dirIdx;
  logic [IDX_W-1:0]  tblIdx;

  always_comb begin
    dirIdx  = linReg[ADDR_W-1:DIR_LO];
    tblIdx  = linReg[TBL_HI:TBL_LO];
    dirAddr = {cr3Frame, dirIdx, {ENT_SHIFT{1'b0}}};
    tblAddr = {dirEnt[ADDR_W-1:OFF_W], tblIdx, {ENT_SHIFT{1'b0}}};
    memAddr = stb.selTbl ? tblAddr : dirAddr;
    if (stb.selTbl)
      memWdata = tblEnt | MASK_A | (wrReg ? MASK_D : '0);
    else
      memWdata = dirEnt | MASK_A;
  end

  // Decisions taken on the word returned by the current read.
  logic userOk;
  logic writeOk;

  always_comb begin
    rdPresent  = memRdata[BIT_P];
    dirNeedsWb = !memRdata[BIT_A];
    tblNeedsWb = !memRdata[BIT_A] || (wrReg && !memRdata[BIT_D]);
    userOk     = dirEnt[BIT_US] && memRdata[BIT_US];
    writeOk    = dirEnt[BIT_RW] && memRdata[BIT_RW];
    protOk     = !usrReg || (userOk && (!wrReg || writeOk));
  end

  assign physAddr  = pgReg ? {tblEnt[ADDR_W-1:OFF_W], linReg[OFF_W-1:0]} : linReg;
  assign faultAddr = cr2Reg;
  assign faultErr  = errReg;

  // A write-back only ever targets a present entry and marks it accessed.
  AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |-> (memWdata[BIT_P] && memWdata[BIT_A])); // R7

endmodule

// File: rtl/walkCtrl.sv
module walkCtrl
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        pagingOn,
  input  logic        memAck,
  input  logic        rdPresent,
  input  logic        dirNeedsWb,
  input  logic        tblNeedsWb,
  input  logic        protOk,
  output walkStrobe_t stb,
  output logic        memReq,
  output logic        memWe,
  output logic        walkDone,
  output logic        walkFault
);

  walkState_t state;
  walkState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    walkDone  = 1'b0;
    walkFault = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.capture = 1'b1;
          nextState   = pagingOn ? ST_RD_DIR : ST_FIN;
        end
      end
      ST_RD_DIR: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.latchDir = 1'b1;
          if (!rdPresent) begin
            stb.loadCr2 = 1'b1;
            nextState   = ST_FLT;
          end else begin
            nextState = dirNeedsWb ? ST_WR_DIR : ST_RD_TBL;
          end
        end
      end
      ST_WR_DIR: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        stb.doWrite = 1'b1;
        if (memAck) nextState = ST_RD_TBL;
      end
      ST_RD_TBL: begin
        memReq     = 1'b1;
        stb.selTbl = 1'b1;
        if (memAck) begin
          stb.latchTbl = 1'b1;
          if (!rdPresent) begin
            stb.loadCr2 = 1'b1;
            nextState   = ST_FLT;
          end else if (!protOk) begin
            stb.loadCr2   = 1'b1;
            stb.faultProt = 1'b1;
            nextState     = ST_FLT;
          end else begin
            nextState = tblNeedsWb ? ST_WR_TBL : ST_FIN;
          end
        end
      end
      ST_WR_TBL: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        stb.selTbl  = 1'b1;
        stb.doWrite = 1'b1;
        if (memAck) nextState = ST_FIN;
      end
      ST_FIN: begin
        walkDone  = 1'b1;
        nextState = ST_IDLE;
      end
      ST_FLT: begin
        walkFault = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(walkDone && walkFault)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && (memWe == $past(memWe)))); // R3

endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              isUser,
  input  logic              pagingOn,
  input  logic [ADDR_W-1:0] cr3Base,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              walkDone,
  output logic              walkFault,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [2:0]        faultErr
);

  walkStrobe_t stb;
  logic rdPresent;
  logic dirNeedsWb;
  logic tblNeedsWb;
  logic protOk;

  walkCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .pagingOn   (pagingOn),
    .memAck     (memAck),
    .rdPresent  (rdPresent),
    .dirNeedsWb (dirNeedsWb),
    .tblNeedsWb (tblNeedsWb),
    .protOk     (protOk),
    .stb        (stb),
    .memReq     (memReq),
    .memWe      (memWe),
    .walkDone   (walkDone),
    .walkFault  (walkFault)
  );

  walkPath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .linAddr    (linAddr),
    .isWrite    (isWrite),
    .isUser     (isUser),
    .pagingOn   (pagingOn),
    .cr3Base    (cr3Base),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .physAddr   (physAddr),
    .faultAddr  (faultAddr),
    .faultErr   (faultErr),
    .rdPresent  (rdPresent),
    .dirNeedsWb (dirNeedsWb),
    .tblNeedsWb (tblNeedsWb),
    .protOk     (protOk)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr)); // R3

  AST_CR2_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !walkFault |=> (walkFault || $stable(faultAddr))); // R9

endmodule

// File: tb/pageWalker_bench.sv
module pageWalker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] linAddr = '0;
  logic        isWrite = 1'b0;
  logic        isUser = 1'b0;
  logic        pagingOn = 1'b0;
  logic [31:0] cr3Base = 32'h0000_1000;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        walkDone, walkFault;
  logic [31:0] physAddr, faultAddr;
  logic [2:0]  faultErr;

  always #2 clk = ~clk;   // 250 MHz

  pageWalker u_pageWalker (
    .clk (clk), .rstN (rstN), .startReq (startReq), .linAddr (linAddr),
    .isWrite (isWrite), .isUser (isUser), .pagingOn (pagingOn), .cr3Base (cr3Base),
    .memReq (memReq), .memWe (memWe), .memAddr (memAddr), .memWdata (memWdata),
    .memAck (memAck), .memRdata (memRdata), .walkDone (walkDone), .walkFault (walkFault),
    .physAddr (physAddr), .faultAddr (faultAddr), .faultErr (faultErr)
  );

  // Memory model: one-cycle acknowledge, 16 KB of words.
  logic [31:0] mem [4096];
  logic        prep = 1'b0;
  int          wrCount, reqCount, accIdx;
  logic [31:0] acc [4];

  always @(posedge clk) begin
    if (prep) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      mem[12'h400] <= 32'h0000_2007;  // dir 0: table 0x2000, user rw, A clear
      mem[12'h401] <= 32'h0000_3025;  // dir 1: table 0x3000, user read-only, A set
      mem[12'h403] <= 32'h0000_3023;  // dir 3: table 0x3000, supervisor, A set
      mem[12'h800] <= 32'hABCD_E007;  // user rw, A/D clear
      mem[12'h801] <= 32'h1234_5065;  // user read-only, A/D set
      mem[12'h803] <= 32'h5555_5023;  // supervisor rw, A set
      mem[12'hBFF] <= 32'hFFFF_F067;  // user rw, A/D set
      mem[12'hC00] <= 32'h0077_7027;  // user rw, A set, D clear
      wrCount  <= 0;
      reqCount <= 0;
      accIdx   <= 0;
      memAck   <= 1'b0;
    end else if (!rstN) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      memAck   <= 1'b1;
      memRdata <= mem[memAddr[13:2]];
      if (memWe) begin
        mem[memAddr[13:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end
      if (accIdx < 4) acc[accIdx] <= memAddr;
      accIdx   <= accIdx + 1;
      reqCount <= reqCount + 1;
    end else begin
      memAck <= 1'b0;
    end
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 got hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic        sDone, sFault;
  logic [31:0] sPhys, sCr2;
  logic [2:0]  sErr;

  task automatic doPrep();
    @(negedge clk); prep = 1'b1;
    @(negedge clk); prep = 1'b0;
  endtask

  task automatic runWalk(input logic [31:0] a, input logic w, input logic u,
                         input logic p, input logic poke);
    int n;
    @(negedge clk);
    linAddr = a; isWrite = w; isUser = u; pagingOn = p; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      @(negedge clk);
      startReq = 1'b1; linAddr = 32'h0080_0000; isWrite = 1'b1; isUser = 1'b0;
      @(negedge clk);
      startReq = 1'b0;
    end
    n = 0;
    while (!walkDone && !walkFault && n < 200) begin
      @(negedge clk);
      n++;
    end
    sDone = walkDone; sFault = walkFault; sPhys = physAddr;
    sErr = faultErr; sCr2 = faultAddr;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [31:0] phys;
    logic [2:0]  err;
    logic [1:0]  nWr;
    logic [15:0] chkAddr;
    logic [31:0] chkVal;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0123, 1'b0, 1'b1, 1'b0, 32'hABCD_E123, 3'd0, 2'd2, 16'h2000, 32'hABCD_E027},
    '{32'h0000_0FFF, 1'b1, 1'b1, 1'b0, 32'hABCD_EFFF, 3'd0, 2'd2, 16'h2000, 32'hABCD_E067},
    '{32'h0000_1010, 1'b0, 1'b1, 1'b0, 32'h1234_5010, 3'd0, 2'd1, 16'h1000, 32'h0000_2027},
    '{32'h0000_1020, 1'b1, 1'b1, 1'b1, 32'h0,         3'd7, 2'd1, 16'h2004, 32'h1234_5065},
    '{32'h0000_1030, 1'b1, 1'b0, 1'b0, 32'h1234_5030, 3'd0, 2'd1, 16'h1000, 32'h0000_2027},
    '{32'h0000_2040, 1'b0, 1'b1, 1'b1, 32'h0,         3'd4, 2'd1, 16'h2008, 32'h0},
    '{32'h0080_0050, 1'b0, 1'b0, 1'b1, 32'h0,         3'd0, 2'd0, 16'h1000, 32'h0000_2007},
    '{32'h0000_3060, 1'b0, 1'b1, 1'b1, 32'h0,         3'd5, 2'd1, 16'h200C, 32'h5555_5023},
    '{32'h0000_3070, 1'b0, 1'b0, 1'b0, 32'h5555_5070, 3'd0, 2'd1, 16'h1000, 32'h0000_2027},
    '{32'h0040_0080, 1'b1, 1'b1, 1'b1, 32'h0,         3'd7, 2'd0, 16'h3000, 32'h0077_7027},
    '{32'h0040_0090, 1'b0, 1'b1, 1'b0, 32'h0077_7090, 3'd0, 2'd0, 16'h3000, 32'h0077_7027},
    '{32'h00C0_00A0, 1'b0, 1'b1, 1'b1, 32'h0,         3'd5, 2'd0, 16'h100C, 32'h0000_3023},
    '{32'h003F_FABC, 1'b1, 1'b1, 1'b0, 32'hFFFF_FABC, 3'd0, 2'd1, 16'h2FFC, 32'hFFFF_F067},
    '{32'h0040_00B0, 1'b1, 1'b0, 1'b0, 32'h0077_70B0, 3'd0, 2'd1, 16'h3000, 32'h0077_7067}
  };

  initial begin
    doPrep();
    // R1: outputs during and right after reset
    chk("R1 done in reset", {31'd0, walkDone}, 32'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 req", {31'd0, memReq}, 32'd0);
    chk("R1 done/fault", {30'd0, walkDone, walkFault}, 32'd0);
    chk("R1 faultAddr", faultAddr, 32'd0);
    chk("R1 faultErr", {29'd0, faultErr}, 32'd0);

    // Table of walks, each on freshly loaded tables
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      doPrep();
      runWalk(v.lin, v.wr, v.usr, 1'b1, 1'b0);
      chk($sformatf("R5/R6 fault flag vec%0d", i), {31'd0, sFault}, {31'd0, v.flt});
      chk($sformatf("R4 done flag vec%0d", i), {31'd0, sDone}, {31'd0, !v.flt});
      if (!v.flt) begin
        chk($sformatf("R4 phys vec%0d", i), sPhys, v.phys);
      end else begin
        chk($sformatf("R10 err vec%0d", i), {29'd0, sErr}, {29'd0, v.err});
        chk($sformatf("R9 faultAddr vec%0d", i), sCr2, v.lin);
      end
      chk($sformatf("R7/R8 writes vec%0d", i), wrCount, {30'd0, v.nWr});
      chk($sformatf("R8 entry word vec%0d", i), mem[v.chkAddr[13:2]], v.chkVal);
      chk($sformatf("R3 dir addr vec%0d", i), acc[0], 32'h1000 + {20'd0, v.lin[31:22], 2'b00});
      if (i == 12) chk("R3 table addr", acc[2], 32'h0000_2FFC);
      if (i == 0)  chk("R7 dir write before table read", acc[1], 32'h0000_1000);
    end

    // R2: paging disabled
    doPrep();
    runWalk(32'h89AB_CDEF, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 done", {31'd0, sDone}, 32'd1);
    chk("R2 phys", sPhys, 32'h89AB_CDEF);
    chk("R2 no request", reqCount, 0);

    // R11: start and input changes during a walk are ignored
    doPrep();
    runWalk(32'h0000_0123, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R11 phys kept", sPhys, 32'hABCD_E123);
    repeat (3) @(negedge clk);
    chk("R11 no second walk", {31'd0, memReq}, 32'd0);
    chk("R11 request count", reqCount, 4);

    // R9: fault address held across a later successful walk
    doPrep();
    runWalk(32'h0000_1020, 1'b1, 1'b1, 1'b1, 1'b0);
    runWalk(32'h0000_1010, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 hold after success", faultAddr, 32'h0000_1020);
    chk("R10 err held", {29'd0, faultErr}, 32'd7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule